// File: doc/BRIEF.md
# Limit-Register Interval Timer

A bank of periodic interval timers on one word-addressed register port. The bank holds one system timer and one timer for each CPU. Every timer advances on a shared microsecond tick enable. Software loads a period into a limit register. The timer counts toward that limit, wraps, and holds its interrupt line high until software acknowledges it.

The acknowledge is a side effect of reading the limit word. A second copy of the limit word, the no-clear alias, reads and writes the same limit without disturbing a pending interrupt or the running count. The limit and count values sit in a field that starts at bit 10. Bit 31 of the limit and count reads mirrors the pending flag. To get a period of P ticks, software writes (P+1) shifted left by 10.

A configuration word in the system timer's region turns any per-CPU timer into a free-running user counter. In that mode the timer's start/stop word gates counting, and the timer raises no interrupts.

Top module: `lim_timer_top`

## Requirements
- R1: After reset every interrupt output is low, and every limit, count, start/stop and configuration word reads as 0.
- R2: A read request is answered with the data on rdata_o and rvalid_o high in the cycle after the request. Limit reads (word 0 and word 2) and count reads (word 1) return the flag in bit 31, the value in bits 30:10, and zeros in bits 9:0.
- R3: A write to word 0 loads bits 30:10 as the limit L and restarts the count at 1. While L is nonzero, each tick adds 1 to the count. On a tick where count+1 >= L, the count returns to 1 and the flag sets. The interrupt therefore rises on the tick L-1 after the write, and every L-1 ticks after that.
- R4: A read of word 0 clears the flag, and the interrupt is low in the cycle after the read. If a wrap occurs in the same cycle as that read, the flag stays set.
- R5: Word 2 reads the same value as word 0 without clearing the flag. A write to word 2 changes the limit but leaves the count and the flag as they were.
- R6: While the limit is 0, a timer in periodic mode holds its count and never sets its flag.
- R7: Per-CPU timer k occupies words 4k..4k+3 and drives irq_cpu_o[k]. The system timer occupies words 4N..4N+3, where N is NUM_CPU, and drives irq_sys_o. The configuration word is word 4N+4. Word 3 of a per-CPU timer holds the start bit in bit 0. Word 3 of the system timer reads 0 and ignores writes.
- R8: With configuration bit k set, per-CPU timer k is a user counter. It adds 1 on each tick while its start bit is 1, holds while the start bit is 0, ignores its limit for wrapping, and never sets its flag.
- R9: Writes to the count word (word 1) have no effect.
- R10: A write to word 0 in the same cycle as a tick wins: the count becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle microsecond tick enable |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| irq_sys_o | output | 1 | System timer interrupt (level) |
| irq_cpu_o | output | NUM_CPU | Per-CPU timer interrupts (level) |

## Verification
The assertions take for granted that tick_i is a single-cycle strobe sampled on the clock edge. They also assume that a register access finishes in one request cycle, with no back-pressure. The stimulus drives every input half a cycle away from the active edge and holds each request for exactly one cycle. Ticks are kept apart from register accesses except in the directed cases that exercise the read-versus-wrap and write-versus-tick collisions. The randomised runs pick limits from 2 to 31 and tick counts up to 69, which keeps every count well below the field width.

// File: rtl/lt_pkg.sv
package lt_pkg;
  parameter int DATA_W  = 32;
  parameter int FLD_LSB = 10;
  localparam int FLD_W  = DATA_W - 1 - FLD_LSB;

  typedef enum logic [1:0] {
    W_LIM = 2'd0,
    W_CNT = 2'd1,
    W_NCL = 2'd2,
    W_AUX = 2'd3
  } word_e;

  function automatic logic [DATA_W-1:0] pack_fld(input logic flag, input logic [FLD_W-1:0] val);
    return {flag, val, {FLD_LSB{1'b0}}};
  endfunction
endpackage

// File: rtl/lt_bus_dec.sv
module lt_bus_dec #(
  parameter int NUM_CPU = 2,
  parameter int ADDR_W  = 4
) (
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_CPU:0]  inst_sel_o,
  output logic              cfg_sel_o,
  output logic [1:0]        word_o
);
  localparam int INST_W = ADDR_W - 2;

  logic [INST_W-1:0] inst;
  assign inst   = addr_i[ADDR_W-1:2];
  assign word_o = addr_i[1:0];

  // index NUM_CPU is the system timer
  for (genvar k = 0; k <= NUM_CPU; k++) begin : g_sel
    assign inst_sel_o[k] = req_i && (inst == INST_W'(k));
  end

  assign cfg_sel_o = req_i && (inst == INST_W'(NUM_CPU + 1)) && (addr_i[1:0] == 2'd0);
endmodule

// File: rtl/lt_counter.sv
module lt_counter
  import lt_pkg::*;
#(
  parameter bit IS_CPU = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              user_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [1:0]        word_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [FLD_W-1:0] lim_q, cnt_q, new_lim;
  logic [FLD_W:0]   cnt_inc;
  logic             flag_q, run_q;
  logic             wr_lim, wr_ncl, wr_aux, rd_clr;
  logic             periodic, advance, wrap;

  assign wr_lim  = sel_i &&  we_i && (word_i == W_LIM);
  assign wr_ncl  = sel_i &&  we_i && (word_i == W_NCL);
  assign wr_aux  = sel_i &&  we_i && (word_i == W_AUX);
  assign rd_clr  = sel_i && !we_i && (word_i == W_LIM);
  assign new_lim = wdata_i[FLD_LSB +: FLD_W];

  assign periodic = !(IS_CPU && user_i);
  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  assign advance  = tick_i && (periodic ? (lim_q != '0) : run_q);
  // >= so a limit lowered through the alias below the count still wraps
  assign wrap     = periodic && advance && (cnt_inc >= {1'b0, lim_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q  <= '0;
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_lim || wr_ncl) lim_q <= new_lim;
      if (wr_lim)           cnt_q <= FLD_W'(1);
      else if (advance)     cnt_q <= wrap ? FLD_W'(1) : cnt_inc[FLD_W-1:0];
      if (wrap)             flag_q <= 1'b1;
      else if (rd_clr)      flag_q <= 1'b0;
    end
  end

  if (IS_CPU) begin : g_run
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     run_q <= 1'b0;
      else if (wr_aux) run_q <= wdata_i[0];
    end
  end else begin : g_norun
    assign run_q = 1'b0;
  end

  always_comb begin
    unique case (word_i)
      W_LIM, W_NCL: rdata_o = pack_fld(flag_q, lim_q);
      W_CNT:        rdata_o = pack_fld(flag_q, cnt_q);
      default:      rdata_o = {{(DATA_W-1){1'b0}}, run_q};
    endcase
  end

  assign irq_o = flag_q;

  a_r3_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (periodic && !wr_lim && !wr_ncl && lim_q != '0 && cnt_q != '0 && cnt_q < lim_q)
      |=> (cnt_q <= lim_q));
  a_r4_rise_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(tick_i));
  a_r6_zero_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (periodic && lim_q == '0 && !wr_lim) |=> $stable(cnt_q));
  a_r8_user_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!periodic && !run_q && !wr_lim) |=> $stable(cnt_q));
  a_r8_user_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!periodic && !flag_q) |=> !flag_q);
  a_r10_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lim |=> (cnt_q == FLD_W'(1)));
endmodule

// File: rtl/lt_rd_mux.sv
module lt_rd_mux
  import lt_pkg::*;
#(
  parameter int NUM_CPU = 2
) (
  input  logic [NUM_CPU:0][DATA_W-1:0] inst_rd_i,
  input  logic [NUM_CPU:0]             inst_sel_i,
  input  logic                         cfg_sel_i,
  input  logic [NUM_CPU-1:0]           cfg_i,
  output logic [DATA_W-1:0]            rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int k = 0; k <= NUM_CPU; k++)
      if (inst_sel_i[k]) rdata_o = rdata_o | inst_rd_i[k];
    if (cfg_sel_i) rdata_o = rdata_o | {{(DATA_W-NUM_CPU){1'b0}}, cfg_i};
  end
endmodule

// File: rtl/lim_timer_top.sv
module lim_timer_top
  import lt_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int ADDR_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic               rvalid_o,
  output logic               irq_sys_o,
  output logic [NUM_CPU-1:0] irq_cpu_o
);
  logic [NUM_CPU:0]             inst_sel;
  logic [NUM_CPU:0][DATA_W-1:0] inst_rd;
  logic [NUM_CPU:0]             inst_irq;
  logic                         cfg_sel;
  logic [1:0]                   word;
  logic [NUM_CPU-1:0]           cfg_q;
  logic [DATA_W-1:0]            rd_mux, rdata_q;
  logic                         rvalid_q;

  lt_bus_dec #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) i_dec (
    .req_i      (req_i),
    .addr_i     (addr_i),
    .inst_sel_o (inst_sel),
    .cfg_sel_o  (cfg_sel),
    .word_o     (word)
  );

  for (genvar k = 0; k <= NUM_CPU; k++) begin : g_tmr
    localparam bit CPU = (k < NUM_CPU);
    logic user;
    if (CPU) begin : g_u
      assign user = cfg_q[k];
    end else begin : g_nu
      assign user = 1'b0;
    end
    lt_counter #(.IS_CPU(CPU)) i_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .user_i  (user),
      .sel_i   (inst_sel[k]),
      .we_i    (we_i),
      .word_i  (word),
      .wdata_i (wdata_i),
      .rdata_o (inst_rd[k]),
      .irq_o   (inst_irq[k])
    );
  end

  lt_rd_mux #(.NUM_CPU(NUM_CPU)) i_mux (
    .inst_rd_i  (inst_rd),
    .inst_sel_i (inst_sel),
    .cfg_sel_i  (cfg_sel),
    .cfg_i      (cfg_q),
    .rdata_o    (rd_mux)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (cfg_sel && we_i) cfg_q <= wdata_i[NUM_CPU-1:0];
      rvalid_q <= req_i && !we_i;
      if (req_i && !we_i) rdata_q <= rd_mux;
    end
  end

  assign rdata_o   = rdata_q;
  assign rvalid_o  = rvalid_q;
  assign irq_sys_o = inst_irq[NUM_CPU];
  assign irq_cpu_o = inst_irq[NUM_CPU-1:0];

  a_r2_rvalid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
  a_r2_rvalid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i || we_i) |=> !rvalid_o);
  a_r1_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({inst_sel, cfg_sel}));
endmodule

// File: tb/test_lim_timer_top.sv
module test_lim_timer_top;
  localparam int NUM_CPU = 2;
  localparam int ADDR_W  = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rvalid, irq_sys;
  logic [NUM_CPU-1:0] irq_cpu;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] q;

  lim_timer_top #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) i_lim_timer_top (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .irq_sys_o(irq_sys), .irq_cpu_o(irq_cpu)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] fld(input int v, input bit f);
    return {f, 21'(v), 10'b0};
  endfunction

  function automatic int exp_cnt(input int lim, input int n);
    int c = 1;
    for (int i = 0; i < n; i++) c = (c + 1 >= lim) ? 1 : c + 1;
    return c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc(input bit r, input bit w, input int a, input logic [31:0] d,
                     input bit tk, output logic [31:0] res);
    @(negedge clk);
    req = r; we = w; addr = ADDR_W'(a); wdata = d; tick = tk;
    @(negedge clk);
    req = 1'b0; we = 1'b0; tick = 1'b0;
    res = rdata;
    if (r && !w) chk("R2 rvalid", {31'b0, rvalid}, 32'd1);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    logic [31:0] dummy;
    cyc(1'b1, 1'b1, a, d, 1'b0, dummy);
  endtask

  task automatic rd(input int a, output logic [31:0] res);
    cyc(1'b1, 1'b0, a, 32'h0, 1'b0, res);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {29'b0, irq_sys, irq_cpu}, 32'd0);
    rst_n = 1'b1;
    // R1 reset values
    for (int w = 0; w < 4; w++) begin
      rd(w, q); chk("R1 cpu0 word", q, 32'd0);
    end
    rd(8, q);  chk("R1 sys limit", q, 32'd0);
    rd(12, q); chk("R1 config", q, 32'd0);

    // R3 period and R2 layout
    wr(0, fld(5, 0));
    ticks(3); chk("R3 no irq before period", {31'b0, irq_cpu[0]}, 32'd0);
    ticks(1); chk("R3 irq at period", {31'b0, irq_cpu[0]}, 32'd1);
    rd(1, q); chk("R2 count after wrap", q, fld(1, 1));

    // R5 alias read keeps flag; R4 word 0 read clears
    rd(2, q); chk("R5 alias read data", q, fld(5, 1));
    chk("R5 alias read keeps irq", {31'b0, irq_cpu[0]}, 32'd1);
    rd(0, q); chk("R4 limit read data", q, fld(5, 1));
    chk("R4 irq cleared", {31'b0, irq_cpu[0]}, 32'd0);

    // R5 alias write keeps count and flag
    ticks(2);
    wr(2, fld(10, 0));
    rd(1, q); chk("R5 alias write keeps count", q, fld(3, 0));
    ticks(6); chk("R5 no irq before new limit", {31'b0, irq_cpu[0]}, 32'd0);
    ticks(1); chk("R5 irq at new limit", {31'b0, irq_cpu[0]}, 32'd1);
    wr(2, fld(10, 0));
    chk("R5 alias write keeps irq", {31'b0, irq_cpu[0]}, 32'd1);
    rd(1, q); chk("R5 count after alias write", q, fld(1, 1));

    // R9 count word is read-only
    wr(1, 32'hFFFF_FFFF);
    rd(1, q); chk("R9 count write ignored", q, fld(1, 1));
    rd(0, q);

    // R4 wrap during clearing read keeps flag
    wr(0, fld(2, 0));
    ticks(1);
    cyc(1'b1, 1'b0, 0, 32'h0, 1'b1, q);
    chk("R4 read data during wrap", q, fld(2, 1));
    chk("R4 wrap beats clear", {31'b0, irq_cpu[0]}, 32'd1);
    rd(0, q); chk("R4 clear without wrap", {31'b0, irq_cpu[0]}, 32'd0);

    // R10 write beats tick
    wr(0, fld(4, 0));
    ticks(1);
    cyc(1'b1, 1'b1, 0, fld(7, 0), 1'b1, q);
    rd(1, q); chk("R10 write wins over tick", q, fld(1, 0));

    // R6 limit zero holds
    wr(0, 32'd0);
    wr(4, 32'd0);
    ticks(50);
    rd(5, q); chk("R6 cpu1 count held", q, fld(1, 0));
    rd(1, q); chk("R6 cpu0 count held", q, fld(1, 0));
    chk("R6 no irq", {30'b0, irq_cpu}, 32'd0);

    // R7 system timer mapping
    wr(8, fld(3, 0));
    ticks(2);
    chk("R7 sys irq", {31'b0, irq_sys}, 32'd1);
    chk("R7 cpu irqs untouched", {30'b0, irq_cpu}, 32'd0);
    rd(8, q); chk("R7 sys limit read", q, fld(3, 1));
    chk("R7 sys irq cleared", {31'b0, irq_sys}, 32'd0);
    wr(8, 32'd0);
    wr(11, 32'd1);
    rd(11, q); chk("R7 sys word3 reads 0", q, 32'd0);

    // R8 user counter on cpu1
    wr(12, 32'd2);
    rd(12, q); chk("R8 config readback", q, 32'd2);
    wr(4, fld(3, 0));
    wr(7, 32'd1);
    rd(7, q); chk("R7 cpu1 start readback", q, 32'd1);
    ticks(10);
    chk("R8 user no irq", {31'b0, irq_cpu[1]}, 32'd0);
    rd(5, q); chk("R8 user counts past limit", q, fld(11, 0));
    wr(7, 32'd0);
    ticks(5);
    rd(5, q); chk("R8 stopped holds", q, fld(11, 0));
    wr(7, 32'd1);
    ticks(4);
    rd(5, q); chk("R8 restarted", q, fld(15, 0));
    wr(12, 32'd0);
    wr(4, 32'd0);
    rd(4, q);

    // random periods across all timers
    for (int i = 0; i < 24; i++) begin
      int inst = i % 3;
      int base = inst * 4;
      int lim  = 2 + int'($urandom % 30);
      int n    = int'($urandom % 70);
      bit f    = (n >= lim - 1);
      logic irq_now;
      wr(base, fld(lim, 0));
      ticks(n);
      irq_now = (inst == 2) ? irq_sys : irq_cpu[inst];
      chk("R3 random irq", {31'b0, irq_now}, {31'b0, f});
      rd(base + 1, q); chk("R3 random count", q, fld(exp_cnt(lim, n), f));
      rd(base, q);     chk("R4 random limit read", q, fld(lim, f));
      irq_now = (inst == 2) ? irq_sys : irq_cpu[inst];
      chk("R4 random cleared", {31'b0, irq_now}, 32'd0);
      wr(base, 32'd0);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule